// File: doc/BRIEF.md
# Passive LCD Timing Generator

This block produces the strobes that drive a passive-matrix STN panel: a shift clock, a line pulse, a frame pulse and an AC-bias signal that alternates the drive polarity. It divides the master clock down to a shift-clock rate, counts transfers across each line and lines across each frame, and tells a downstream pixel formatter when to present data through a one-cycle request strobe for every data beat. It does not fetch or format pixels.

Configuration arrives on plain input pins in register style: a shift-clock divisor, a per-line transfer count and a line count (both programmed minus one), an AC-bias divisor, a split-panel select, an 8-bit-interface select, a video polarity bit, and separate enable and display-on bits. The programmed values are captured while the engine is stopped and again at each frame boundary, so software may rewrite them at any time without tearing a frame. A live line counter is brought out for software to read.

For a 4-bit or split panel the transfer count holds 4-bit transfers per line minus one; for an 8-bit single panel it holds 8-bit transfers minus one. For a split panel the line count holds lines per half minus one. The timing itself is the same in all three cases; the captured interface kind is reported on `xfer_mode` for the formatter.

Top module: `lcd_timing_gen`

## Requirements
- R1: With divisor N captured, `lcd_shclk` is low for N+1 master cycles and then high for N+1 cycles, repeating with period 2N+2, and is low in the first cycle after enable rises.
- R2: Each line consists of H+1 data beats (H the captured transfer count) followed by one line-pulse beat; `lcd_line` is high for exactly that beat of 2N+2 cycles and low otherwise.
- R3: `pix_req` is high for one master cycle at the first cycle of every data beat and never during the line-pulse beat; it is not gated by display-on.
- R4: `line_count` counts lines 0 to V (V the captured line count) and wraps to 0; `lcd_frame` is high for the whole of line 0 of each frame and low on all other lines.
- R5: `lcd_acbias` starts low and toggles at the end of every (D+1)-th line (D the captured bias divisor), counting lines continuously across frame boundaries.
- R6: While `cfg_enable` is low, in the same cycle, all outputs except `xfer_mode` are low and `line_count` is 0; when enable rises again the timing restarts at beat 0 of line 0 with `lcd_acbias` low.
- R7: While `cfg_disp_on` is low, `lcd_shclk`, `lcd_line`, `lcd_frame`, `lcd_acbias` and `video_inv` are low, while `pix_req` and `line_count` keep following the timing.
- R8: All configuration except enable and display-on is captured while disabled and at the end of the last line of a frame; a change made in mid-frame has no effect until line 0 of the next frame.
- R9: `xfer_mode` reports the captured interface kind: 2 for a split panel (split select 1, whatever the 8-bit select), 1 for an 8-bit single panel, 0 for a 4-bit single panel; `video_inv` equals the captured polarity bit while enabled and displayed.
- R10: While `rst_n` is low, synchronously, all state including the captured configuration is cleared, so `xfer_mode` reads 0 and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Runs the timing engine; low holds all counters at zero |
| cfg_disp_on | input | 1 | Gates the panel strobes |
| cfg_invert | input | 1 | Video polarity select |
| cfg_split | input | 1 | Split (dual-half) panel select |
| cfg_wide8 | input | 1 | 8-bit interface select for a single panel |
| cfg_clk_div | input | DIV_W (5) | Shift-clock divisor N, period 2N+2 |
| cfg_hcount | input | HC_W (9) | Transfers per line minus one |
| cfg_lcount | input | LC_W (10) | Lines per frame (or per half) minus one |
| cfg_df_div | input | DF_W (8) | Lines per AC-bias half-period minus one |
| lcd_shclk | output | 1 | Panel shift clock |
| lcd_line | output | 1 | Line pulse |
| lcd_frame | output | 1 | Frame pulse |
| lcd_acbias | output | 1 | AC-bias toggle |
| video_inv | output | 1 | Captured polarity for the data path |
| xfer_mode | output | 2 | Captured interface kind |
| pix_req | output | 1 | One-cycle data request per data beat |
| line_count | output | LC_W (10) | Live line counter |

## Verification
A wrong prescaler state shows within one shift-clock period as a stretched or shortened half on `lcd_shclk`, and shifts every `pix_req` after it. A wrong beat or line counter shows within one line as a misplaced `lcd_line` beat or a `line_count` that skips or overruns the captured limit, while a bias counter fault shows only after D+1 lines as a mis-timed `lcd_acbias` edge, so bench runs cover several frames and several bias periods. A faulty capture path shows one frame late, which is why the mid-frame rewrite test watches both the frame in progress and the next one.

// File: rtl/lcd_tg_pkg.sv
// Shared types for the passive LCD timing generator.
// Assumes: two-bit encoding of the panel interface kind is decoded downstream.
package lcd_tg_pkg;

    typedef enum logic [1:0] {
        XM_NARROW = 2'd0,
        XM_WIDE   = 2'd1,
        XM_SPLIT  = 2'd2
    } xfer_mode_e;

    // Maps the split and 8-bit selects to the interface kind; split wins.
    function automatic xfer_mode_e mode_of(input logic split, input logic wide8);
        if (split)
            return XM_SPLIT;
        else if (wide8)
            return XM_WIDE;
        else
            return XM_NARROW;
    endfunction

endpackage

// File: rtl/lcd_tg_shadow.sv
// Holds the configuration used by the timing engine.
// Copies the live inputs whenever load is high (engine stopped or frame end)
// and holds them otherwise, so mid-frame writes cannot tear a frame.
module lcd_tg_shadow #(
    parameter int DIV_W = 5,
    parameter int HC_W  = 9,
    parameter int LC_W  = 10,
    parameter int DF_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] in_div,
    input  logic [HC_W-1:0]  in_hc,
    input  logic [LC_W-1:0]  in_lc,
    input  logic [DF_W-1:0]  in_df,
    input  logic             in_split,
    input  logic             in_wide8,
    input  logic             in_inv,
    output logic [DIV_W-1:0] sh_div,
    output logic [HC_W-1:0]  sh_hc,
    output logic [LC_W-1:0]  sh_lc,
    output logic [DF_W-1:0]  sh_df,
    output logic             sh_split,
    output logic             sh_wide8,
    output logic             sh_inv
);

    // Capture the configuration on load, clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_div   <= '0;
            sh_hc    <= '0;
            sh_lc    <= '0;
            sh_df    <= '0;
            sh_split <= 1'b0;
            sh_wide8 <= 1'b0;
            sh_inv   <= 1'b0;
        end else if (load) begin
            sh_div   <= in_div;
            sh_hc    <= in_hc;
            sh_lc    <= in_lc;
            sh_df    <= in_df;
            sh_split <= in_split;
            sh_wide8 <= in_wide8;
            sh_inv   <= in_inv;
        end
    end

endmodule

// File: rtl/lcd_tg_prescale.sv
// Divides the master clock into shift-clock beats of 2*(div+1) cycles.
// The first half of each beat has the phase low, the second half high.
// Assumes: div is stable while run is high except at beat boundaries.
module lcd_tg_prescale #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             phase,
    output logic             beat_start,
    output logic             beat_end
);

    logic [DIV_W-1:0] cnt;
    logic             half_done;

    // Detect the last cycle of the current half period.
    assign half_done = (cnt == div);

    // Count master cycles in each half and flip the phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (half_done) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + DIV_W'(1);
        end
    end

    // Mark the first and the last master cycle of a beat.
    always_comb begin
        beat_start = run && !phase && (cnt == '0);
        beat_end   = run && phase && half_done;
    end

endmodule

// File: rtl/lcd_tg_scan.sv
// Counts beats within a line and lines within a frame.
// Beats 0..hc carry data, beat hc+1 is the line-pulse beat.
// Assumes: hc and lc only change on the cycle after frame_end or while stopped.
module lcd_tg_scan #(
    parameter int HC_W = 9,
    parameter int LC_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            beat_end,
    input  logic [HC_W-1:0] hc,
    input  logic [LC_W-1:0] lc,
    output logic            in_lp_beat,
    output logic [LC_W-1:0] line_idx,
    output logic            line_end,
    output logic            frame_end
);

    localparam int HX_W = HC_W + 1;

    logic [HX_W-1:0] beat_idx;
    logic [HX_W-1:0] lp_pos;

    // Position of the line-pulse beat, one past the last data beat.
    assign lp_pos = {1'b0, hc} + HX_W'(1);

    // Decode the line-pulse beat and the line and frame boundaries.
    always_comb begin
        in_lp_beat = run && (beat_idx == lp_pos);
        line_end   = beat_end && in_lp_beat;
        frame_end  = line_end && (line_idx == lc);
    end

    // Advance the beat counter per beat and the line counter per line.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            beat_idx <= '0;
            line_idx <= '0;
        end else if (line_end) begin
            beat_idx <= '0;
            line_idx <= frame_end ? '0 : line_idx + LC_W'(1);
        end else if (beat_end) begin
            beat_idx <= beat_idx + HX_W'(1);
        end
    end

endmodule

// File: rtl/lcd_tg_bias.sv
// Generates the AC-bias level: toggles after every (df+1) lines.
// Counts lines continuously, independent of frame boundaries.
module lcd_tg_bias #(
    parameter int DF_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            line_end,
    input  logic [DF_W-1:0] df,
    output logic            bias
);

    logic [DF_W-1:0] lines;

    // Count finished lines and flip the bias level at the divisor.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            lines <= '0;
            bias  <= 1'b0;
        end else if (line_end) begin
            if (lines == df) begin
                lines <= '0;
                bias  <= ~bias;
            end else begin
                lines <= lines + DF_W'(1);
            end
        end
    end

endmodule

// File: rtl/lcd_timing_gen.sv
// Passive LCD timing generator top level.
// Builds shift clock, line pulse, frame pulse, AC-bias and per-beat data
// requests from a captured configuration. Enable low clears all counters;
// display-on low gates only the panel strobes.
module lcd_timing_gen #(
    parameter int DIV_W = 5,
    parameter int HC_W  = 9,
    parameter int LC_W  = 10,
    parameter int DF_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic             cfg_disp_on,
    input  logic             cfg_invert,
    input  logic             cfg_split,
    input  logic             cfg_wide8,
    input  logic [DIV_W-1:0] cfg_clk_div,
    input  logic [HC_W-1:0]  cfg_hcount,
    input  logic [LC_W-1:0]  cfg_lcount,
    input  logic [DF_W-1:0]  cfg_df_div,
    output logic             lcd_shclk,
    output logic             lcd_line,
    output logic             lcd_frame,
    output logic             lcd_acbias,
    output logic             video_inv,
    output logic [1:0]       xfer_mode,
    output logic             pix_req,
    output logic [LC_W-1:0]  line_count
);

    import lcd_tg_pkg::*;

    logic [DIV_W-1:0] sh_div;
    logic [HC_W-1:0]  sh_hcount;
    logic [LC_W-1:0]  sh_lcount;
    logic [DF_W-1:0]  sh_df;
    logic             sh_split;
    logic             sh_wide8;
    logic             sh_inv;

    logic             phase;
    logic             beat_start;
    logic             beat_end;
    logic             in_lp_beat;
    logic [LC_W-1:0]  line_idx;
    logic             line_end;
    logic             frame_end;
    logic             bias;
    logic             shadow_load;
    logic             panel_on;

    // Capture configuration while stopped and at each frame end.
    assign shadow_load = !cfg_enable || frame_end;

    lcd_tg_shadow #(
        .DIV_W(DIV_W), .HC_W(HC_W), .LC_W(LC_W), .DF_W(DF_W)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (shadow_load),
        .in_div   (cfg_clk_div),
        .in_hc    (cfg_hcount),
        .in_lc    (cfg_lcount),
        .in_df    (cfg_df_div),
        .in_split (cfg_split),
        .in_wide8 (cfg_wide8),
        .in_inv   (cfg_invert),
        .sh_div   (sh_div),
        .sh_hc    (sh_hcount),
        .sh_lc    (sh_lcount),
        .sh_df    (sh_df),
        .sh_split (sh_split),
        .sh_wide8 (sh_wide8),
        .sh_inv   (sh_inv)
    );

    lcd_tg_prescale #(
        .DIV_W(DIV_W)
    ) u_prescale (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (cfg_enable),
        .div        (sh_div),
        .phase      (phase),
        .beat_start (beat_start),
        .beat_end   (beat_end)
    );

    lcd_tg_scan #(
        .HC_W(HC_W), .LC_W(LC_W)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (cfg_enable),
        .beat_end   (beat_end),
        .hc         (sh_hcount),
        .lc         (sh_lcount),
        .in_lp_beat (in_lp_beat),
        .line_idx   (line_idx),
        .line_end   (line_end),
        .frame_end  (frame_end)
    );

    lcd_tg_bias #(
        .DF_W(DF_W)
    ) u_bias (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cfg_enable),
        .line_end (line_end),
        .df       (sh_df),
        .bias     (bias)
    );

    // Gate the panel strobes with enable and display-on.
    always_comb begin
        panel_on   = cfg_enable && cfg_disp_on;
        lcd_shclk  = panel_on && phase;
        lcd_line   = panel_on && in_lp_beat;
        lcd_frame  = panel_on && (line_idx == '0);
        lcd_acbias = panel_on && bias;
        video_inv  = panel_on && sh_inv;
    end

    // Drive the formatter-side outputs from the running timing.
    always_comb begin
        pix_req    = cfg_enable && beat_start && !in_lp_beat;
        line_count = cfg_enable ? line_idx : '0;
        xfer_mode  = mode_of(sh_split, sh_wide8);
    end

endmodule

// File: rtl/lcd_tg_checker.sv
// Property checker for the passive LCD timing generator, bound to the top.
module lcd_tg_checker #(
    parameter int LC_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_enable,
    input logic            cfg_disp_on,
    input logic            lcd_line,
    input logic            lcd_frame,
    input logic            lcd_acbias,
    input logic            pix_req,
    input logic [LC_W-1:0] line_count,
    input logic [LC_W-1:0] lc_lim
);

    AST_NO_REQ_IN_LINE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_line |-> !pix_req); // R3

    AST_FRAME_ON_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_frame |-> (line_count == '0)); // R4

    AST_LINE_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && $past(cfg_enable) && !$stable(line_count)) |->
            (line_count == '0 || line_count == $past(line_count) + LC_W'(1))); // R4

    AST_LINE_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enable |-> (line_count <= lc_lim)); // R8

    AST_BIAS_AFTER_LINE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && $past(cfg_enable) && cfg_disp_on && $past(cfg_disp_on)
            && !$stable(lcd_acbias)) |-> $past(lcd_line)); // R5

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !$past(cfg_enable)) |=> (cfg_enable || (!pix_req && !lcd_acbias))); // R6

endmodule

bind lcd_timing_gen lcd_tg_checker #(.LC_W(LC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .cfg_disp_on(cfg_disp_on),
    .lcd_line   (lcd_line),
    .lcd_frame  (lcd_frame),
    .lcd_acbias (lcd_acbias),
    .pix_req    (pix_req),
    .line_count (line_count),
    .lc_lim     (sh_lcount)
);

// File: tb/tb_lcd_timing_gen.sv
`timescale 1ns/1ps
module tb_lcd_timing_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b0, cfg_disp_on = 1'b0, cfg_invert = 1'b0;
    logic       cfg_split = 1'b0, cfg_wide8 = 1'b0;
    logic [4:0] cfg_clk_div = '0;
    logic [8:0] cfg_hcount = '0;
    logic [9:0] cfg_lcount = '0;
    logic [7:0] cfg_df_div = '0;
    logic       lcd_shclk, lcd_line, lcd_frame, lcd_acbias, video_inv, pix_req;
    logic [1:0] xfer_mode;
    logic [9:0] line_count;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lcd_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_disp_on(cfg_disp_on),
        .cfg_invert(cfg_invert), .cfg_split(cfg_split), .cfg_wide8(cfg_wide8),
        .cfg_clk_div(cfg_clk_div), .cfg_hcount(cfg_hcount), .cfg_lcount(cfg_lcount),
        .cfg_df_div(cfg_df_div), .lcd_shclk(lcd_shclk), .lcd_line(lcd_line),
        .lcd_frame(lcd_frame), .lcd_acbias(lcd_acbias), .video_inv(video_inv),
        .xfer_mode(xfer_mode), .pix_req(pix_req), .line_count(line_count)
    );

    typedef struct packed {
        logic       sh;
        logic       ln;
        logic       fr;
        logic       ac;
        logic       req;
        logic [9:0] lc;
    } exp_t;

    // Expected outputs at cycle c after enable, derived from R1..R5.
    function automatic exp_t model(int c, int dv, int hc, int lc, int df);
        exp_t m;
        int bl   = 2 * dv + 2;
        int bpl  = hc + 2;
        int beat = c / bl;
        int ph   = c % bl;
        int line = beat / bpl;
        int bi   = beat % bpl;
        m.sh  = (ph >= dv + 1);
        m.ln  = (bi == bpl - 1);
        m.fr  = ((line % (lc + 1)) == 0);
        m.ac  = (((line / (df + 1)) % 2) == 1);
        m.req = (ph == 0) && (bi != bpl - 1);
        m.lc  = 10'(line % (lc + 1));
        return m;
    endfunction

    int    mis [6];
    int    fa  [6];
    int    fe  [6];
    string nm  [6] = '{"R1 shclk", "R2 line pulse", "R4 frame pulse",
                       "R5 acbias", "R3 pix_req", "R4 line_count"};

    task automatic chk(input bit ok, input string req, input string note,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, note, act, exp);
        end
    endtask

    task automatic cmp_cycle(input exp_t e, input bit disp);
        int a [6];
        int x [6];
        a = '{int'(lcd_shclk), int'(lcd_line), int'(lcd_frame), int'(lcd_acbias),
              int'(pix_req), int'(line_count)};
        x = '{int'(e.sh & disp), int'(e.ln & disp), int'(e.fr & disp), int'(e.ac & disp),
              int'(e.req), int'(e.lc)};
        for (int i = 0; i < 6; i++) begin
            if (a[i] != x[i]) begin
                if (mis[i] == 0) begin
                    fa[i] = a[i];
                    fe[i] = x[i];
                end
                mis[i]++;
            end
        end
    endtask

    task automatic report_run(input string note);
        for (int i = 0; i < 6; i++) begin
            chk(mis[i] == 0, nm[i], note, fa[i], fe[i]);
            mis[i] = 0;
        end
    endtask

    task automatic set_cfg(input int dv, input int hc, input int lc, input int df,
                           input bit sp, input bit wd, input bit inv);
        cfg_clk_div = 5'(dv);
        cfg_hcount  = 9'(hc);
        cfg_lcount  = 10'(lc);
        cfg_df_div  = 8'(df);
        cfg_split   = sp;
        cfg_wide8   = wd;
        cfg_invert  = inv;
    endtask

    // Stop, program, start and compare every cycle against the model.
    task automatic run_window(input int dv, input int hc, input int lc, input int df,
                              input bit sp, input bit wd, input bit inv, input bit disp,
                              input int ncyc, input string note);
        int em;
        @(negedge clk);
        cfg_enable = 1'b0;
        set_cfg(dv, hc, lc, df, sp, wd, inv);
        cfg_disp_on = disp;
        repeat (2) @(negedge clk);
        cfg_enable = 1'b1;
        em = sp ? 2 : (wd ? 1 : 0);
        #1;
        chk(xfer_mode == 2'(em), "R9 xfer_mode", note, int'(xfer_mode), em);
        chk(video_inv == (inv & disp), disp ? "R9 video_inv" : "R7 video_inv", note,
            int'(video_inv), int'(inv & disp));
        for (int c = 0; c < ncyc; c++) begin
            if (c > 0) #1;
            cmp_cycle(model(c, dv, hc, lc, df), disp);
            @(negedge clk);
        end
        report_run(note);
    endtask

    initial begin
        int r_dv, r_hc, r_lc, r_df;
        void'($urandom(32'd24681));
        // R10: reset clears captured configuration and strobes.
        set_cfg(3, 4, 2, 1, 1'b1, 1'b1, 1'b1);
        cfg_disp_on = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(xfer_mode == 2'd0, "R10", "xfer_mode in reset", int'(xfer_mode), 0);
        chk({lcd_shclk, lcd_line, lcd_frame, lcd_acbias, pix_req, video_inv} == 6'b0,
            "R10", "strobes in reset", 0, 0);
        chk(line_count == 10'd0, "R10", "line_count in reset", int'(line_count), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners.
        run_window(0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b1, 200, "min divisors");
        run_window(31, 1, 1, 1, 1'b0, 1'b1, 1'b0, 1'b1, 2000, "max clk divisor");
        run_window(2, 3, 2, 3, 1'b1, 1'b1, 1'b1, 1'b1, 2500, "bias across frames split");
        run_window(1, 2, 1, 0, 1'b0, 1'b1, 1'b1, 1'b0, 500, "R7 display off");

        // R6: drop enable mid-line, outputs clear in the same cycle.
        run_window(1, 1, 2, 0, 1'b0, 1'b0, 1'b0, 1'b1, 37, "before R6 stop");
        cfg_enable = 1'b0;
        #1;
        chk({lcd_shclk, lcd_line, lcd_frame, lcd_acbias, pix_req, video_inv} == 6'b0,
            "R6", "strobes when disabled", 0, 0);
        chk(line_count == 10'd0, "R6", "line_count when disabled", int'(line_count), 0);
        repeat (3) @(negedge clk);
        run_window(1, 1, 2, 0, 1'b0, 1'b0, 1'b0, 1'b1, 300, "R6 restart");

        // R8: rewrite the transfer count in mid-frame.
        @(negedge clk);
        cfg_enable = 1'b0;
        set_cfg(0, 2, 1, 0, 1'b0, 1'b0, 1'b0);
        cfg_disp_on = 1'b1;
        repeat (2) @(negedge clk);
        cfg_enable = 1'b1;
        for (int c = 0; c < 16 + 56; c++) begin
            #1;
            if (c < 16) cmp_cycle(model(c, 0, 2, 1, 0), 1'b1);
            else        cmp_cycle(model(c - 16, 0, 5, 1, 0), 1'b1);
            if (c == 5) cfg_hcount = 9'd5;
            @(negedge clk);
        end
        report_run("R8 mid-frame rewrite");

        // Constrained random configurations.
        for (int k = 0; k < 8; k++) begin
            r_dv = int'($urandom % 4);
            r_hc = int'($urandom % 6);
            r_lc = int'($urandom % 5);
            r_df = int'($urandom % 7);
            run_window(r_dv, r_hc, r_lc, r_df, 1'($urandom % 2), 1'($urandom % 2),
                       1'($urandom % 2), 1'b1, 3000, "random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule